// File: doc/BRIEF.md
# Round-Robin Packet Stream Merger

This block merges several independent ready/valid packet streams into a single output stream. Each input carries a data word, start-of-packet and end-of-packet markers, and a narrow channel field. A rotating arbiter gives the output to one input at a time. The granted input keeps the output for a set number of accepted beats. In packet mode it keeps the output until its end-of-packet beat has been accepted. Only then does the arbiter look for the next requester.

Every output beat carries a channel tag. The tag is the granted input's index placed above that input's own channel field. Identical instances can therefore be stacked into a tree, for example two 16-input stages feeding a 2-input stage, and the receiver can still recover the original source. Only the granted input ever sees ready. A source that raises valid for a single cycle while another input holds the grant is not accepted. The beat is lost, not stored, and this shows at the ports as a missing output beat.

The output is registered. Under downstream backpressure it holds its contents, and no input is accepted until the stalled beat leaves.

Top module: `rrmux_stream`

## Requirements
- R1: A beat moves from input i only on a cycle where in_valid[i] and in_ready[i] are both high. At most one in_ready bit is high at any time. Every accepted input beat appears exactly once on the output.
- R2: When no input holds the grant, the arbiter grants the first requesting input, searching from the index after the last granted one and wrapping from NUM_IN-1 to 0. After reset the search starts at input 0. The grant takes effect one cycle after the request is seen.
- R3: Outside an open packet, a grant is released once SCHED_BEATS beats have been accepted. Under continuous valid with one-beat packets, each input delivers SCHED_BEATS beats in turn, in index order.
- R4: When PKT_MODE is 1, the grant is kept after the beat quota has run out for as long as a packet is open. It is released only after the beat with end-of-packet set has been accepted.
- R5: out_chan equals {granted input index (log2 NUM_IN bits), that input's in_chan value}. out_data, out_sop and out_eop equal the accepted input beat's fields.
- R6: While out_valid is high and out_ready is low, out_data, out_chan, out_sop and out_eop stay unchanged, and every in_ready bit is low.
- R7: An input that raises valid for one cycle while another input holds the grant has zero beats accepted, and no output beat carries its index.
- R8: A granted input that drops valid outside an open packet loses the grant on the next cycle, so another requester can be served.
- R9: While rst_n is low, out_valid is low and every in_ready bit is low.
- R10: A beat accepted at a clock edge is presented on the output right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_IN | Per-input valid |
| in_ready | output | NUM_IN | Per-input ready, high only for the granted input |
| in_data | input | NUM_IN*DATA_W | Input data words, input i at bits [i*DATA_W +: DATA_W] |
| in_sop | input | NUM_IN | Per-input start-of-packet marker |
| in_eop | input | NUM_IN | Per-input end-of-packet marker |
| in_chan | input | NUM_IN*CHIN_W | Channel field of each input, from a lower stage |
| out_valid | output | 1 | Output valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output data word |
| out_sop | output | 1 | Output start-of-packet |
| out_eop | output | 1 | Output end-of-packet |
| out_chan | output | log2(NUM_IN)+CHIN_W | Channel tag: input index above the input's channel field |

## Verification
A wrong grant index shows up in the top bits of out_chan on the very next output beat. A wrong rotation pointer shows up as an input that is served out of order, or skipped, within one round of continuous requests. A beat counter that releases too early splits a packet, which is visible as a foreign tag between a start and an end marker. A counter that releases too late makes one tag repeat more than SCHED_BEATS times. A grant that is never dropped stalls every other input, so its first requested beat never appears.

// File: rtl/rrmux_pkg.sv
package rrmux_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_phase_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rrmux_rr_pick.sv
module rrmux_rr_pick #(
    parameter int NUM_IN = 16,
    parameter int SEL_W  = 4
) (
    input  logic [NUM_IN-1:0] req,
    input  logic [SEL_W-1:0]  last,
    output logic              hit,
    output logic [SEL_W-1:0]  pick
);

    // Walk from the farthest offset down to the nearest one, so the
    // nearest requester after 'last' is the one left standing.
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = NUM_IN; k >= 1; k--) begin
            if (req[(int'(last) + k) % NUM_IN]) begin
                hit  = 1'b1;
                pick = SEL_W'((int'(last) + k) % NUM_IN);
            end
        end
    end

endmodule

// File: rtl/rrmux_grant_ctrl.sv
module rrmux_grant_ctrl
    import rrmux_pkg::*;
#(
    parameter int NUM_IN      = 16,
    parameter int SEL_W       = 4,
    parameter int SCHED_BEATS = 2,
    parameter int PKT_MODE    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] req,
    input  logic              take,
    input  logic              eop_g,
    output logic              active,
    output logic [SEL_W-1:0]  gnt_idx
);

    localparam int CNT_W = $clog2(SCHED_BEATS + 1);
    localparam logic [CNT_W-1:0] QUOTA = CNT_W'(SCHED_BEATS);

    typedef struct packed {
        arb_phase_e       phase;
        logic [SEL_W-1:0] idx;
        logic [SEL_W-1:0] last;
        logic [CNT_W-1:0] cnt;
        logic             in_pkt;
    } gstate_t;

    gstate_t st_d, st_q;

    logic             hit;
    logic [SEL_W-1:0] pick;
    logic             valid_g;
    logic [CNT_W-1:0] cnt_n;
    logic             pkt_n;
    logic             open_pkt;

    rrmux_rr_pick #(
        .NUM_IN (NUM_IN),
        .SEL_W  (SEL_W)
    ) u_pick (
        .req  (req),
        .last (st_q.last),
        .hit  (hit),
        .pick (pick)
    );

    assign valid_g = req[st_q.idx];

    always_comb begin
        st_d     = st_q;
        cnt_n    = st_q.cnt;
        pkt_n    = st_q.in_pkt;
        open_pkt = 1'b0;
        if (st_q.phase == ARB_IDLE) begin
            if (hit) begin
                st_d.phase  = ARB_HOLD;
                st_d.idx    = pick;
                st_d.cnt    = '0;
                st_d.in_pkt = 1'b0;
            end
        end else begin
            if (take) begin
                if (st_q.cnt != QUOTA) begin
                    cnt_n = st_q.cnt + 1'b1;
                end
                pkt_n = !eop_g;
            end
            st_d.cnt    = cnt_n;
            st_d.in_pkt = pkt_n;
            open_pkt    = (PKT_MODE != 0) && pkt_n;
            if (!open_pkt && ((cnt_n >= QUOTA) || (!take && !valid_g))) begin
                st_d.phase = ARB_IDLE;
                st_d.last  = st_q.idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= ARB_IDLE;
            st_q.idx    <= '0;
            st_q.last   <= SEL_W'(NUM_IN - 1);
            st_q.cnt    <= '0;
            st_q.in_pkt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = (st_q.phase == ARB_HOLD);
    assign gnt_idx = st_q.idx;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (st_q.cnt <= QUOTA)); // R3

    AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ((($past(req) >> st_q.idx) & 1) != 0)); // R2

    generate
        if (PKT_MODE != 0) begin : g_pkt
            AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (active && st_q.in_pkt && !(take && eop_g))
                |=> (active && $stable(st_q.idx))); // R4

            AST_QUOTA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                (active && take && eop_g && (st_q.cnt >= QUOTA - 1'b1))
                |=> !active); // R3
        end else begin : g_beat
            AST_QUOTA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                (active && take && (st_q.cnt >= QUOTA - 1'b1))
                |=> !active); // R3
        end
    endgenerate

endmodule

// File: rtl/rrmux_out_reg.sv
module rrmux_out_reg #(
    parameter int PAY_W = 264
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PAY_W-1:0] pay_in,
    input  logic             out_ready,
    output logic             space,
    output logic             out_valid,
    output logic [PAY_W-1:0] pay_out
);

    typedef struct packed {
        logic             vld;
        logic [PAY_W-1:0] pay;
    } ostate_t;

    ostate_t os_d, os_q;

    assign space = !os_q.vld || out_ready;

    always_comb begin
        os_d = os_q;
        if (space) begin
            os_d.vld = load;
            if (load) begin
                os_d.pay = pay_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q.vld <= 1'b0;
            os_q.pay <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign out_valid = os_q.vld;
    assign pay_out   = os_q.pay;

    AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(pay_out))); // R6

    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && space) |=> (out_valid && (pay_out == $past(pay_in)))); // R10

endmodule

// File: rtl/rrmux_stream.sv
module rrmux_stream
    import rrmux_pkg::*;
#(
    parameter int NUM_IN      = 16,
    parameter int DATA_W      = 256,
    parameter int CHIN_W      = 1,
    parameter int SCHED_BEATS = 2,
    parameter int PKT_MODE    = 1,
    localparam int SEL_W      = idx_width(NUM_IN),
    localparam int OCH_W      = SEL_W + CHIN_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IN-1:0]          in_valid,
    output logic [NUM_IN-1:0]          in_ready,
    input  logic [NUM_IN*DATA_W-1:0]   in_data,
    input  logic [NUM_IN-1:0]          in_sop,
    input  logic [NUM_IN-1:0]          in_eop,
    input  logic [NUM_IN*CHIN_W-1:0]   in_chan,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DATA_W-1:0]          out_data,
    output logic                       out_sop,
    output logic                       out_eop,
    output logic [OCH_W-1:0]           out_chan
);

    localparam int PAY_W = OCH_W + 2 + DATA_W;

    logic              active;
    logic [SEL_W-1:0]  gnt;
    logic              space;
    logic              take;
    logic              valid_g;
    logic              sop_g;
    logic              eop_g;
    logic [DATA_W-1:0] data_g;
    logic [CHIN_W-1:0] chan_g;
    logic [PAY_W-1:0]  pay_in;
    logic [PAY_W-1:0]  pay_out;

    rrmux_grant_ctrl #(
        .NUM_IN      (NUM_IN),
        .SEL_W       (SEL_W),
        .SCHED_BEATS (SCHED_BEATS),
        .PKT_MODE    (PKT_MODE)
    ) u_gnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (in_valid),
        .take    (take),
        .eop_g   (eop_g),
        .active  (active),
        .gnt_idx (gnt)
    );

    always_comb begin
        valid_g = in_valid[gnt];
        sop_g   = in_sop[gnt];
        eop_g   = in_eop[gnt];
        data_g  = in_data[int'(gnt)*DATA_W +: DATA_W];
        chan_g  = in_chan[int'(gnt)*CHIN_W +: CHIN_W];
        take    = active && valid_g && space;
        pay_in  = {gnt, chan_g, sop_g, eop_g, data_g};
    end

    generate
        for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_rdy
            assign in_ready[gi] = active && (gnt == SEL_W'(gi)) && space;
        end
    endgenerate

    rrmux_out_reg #(
        .PAY_W (PAY_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .pay_in    (pay_in),
        .out_ready (out_ready),
        .space     (space),
        .out_valid (out_valid),
        .pay_out   (pay_out)
    );

    assign {out_chan, out_sop, out_eop, out_data} = pay_out;

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready)); // R1

    AST_BP_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (in_ready == '0)); // R6

    AST_BP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_chan) && $stable(out_sop)
                                       && $stable(out_eop) && $stable(out_data))); // R6

endmodule

// File: tb/sim_rrmux_stream.sv
`timescale 1ns/1ps
module sim_rrmux_stream;

    localparam int N  = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  in_valid;
    logic [N-1:0]  in_ready;
    logic [N*DW-1:0] in_data;
    logic [N-1:0]  in_sop;
    logic [N-1:0]  in_eop;
    logic [N-1:0]  in_chan;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          out_sop;
    logic          out_eop;
    logic [2:0]    out_chan;

    always #5 clk = ~clk;

    rrmux_stream #(
        .NUM_IN (N), .DATA_W (DW), .CHIN_W (1), .SCHED_BEATS (2), .PKT_MODE (1)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .in_sop (in_sop), .in_eop (in_eop), .in_chan (in_chan),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_sop (out_sop), .out_eop (out_eop), .out_chan (out_chan)
    );

    // source models
    logic [N-1:0] src_on = '0;
    logic [N-1:0] chan_val = '0;
    int src_len [N] = '{1, 1, 1, 1};
    int beat_idx [N];
    int seq [N];
    int acc_cnt [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_valid[i] = src_on[i];
            in_sop[i]   = (beat_idx[i] == 0);
            in_eop[i]   = (beat_idx[i] == src_len[i] - 1);
            in_chan[i]  = chan_val[i];
            in_data[i*DW +: DW] = {8'(i), 24'(seq[i])};
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                beat_idx[i] <= 0;
                seq[i]      <= 0;
                acc_cnt[i]  <= 0;
            end else if (in_valid[i] && in_ready[i]) begin
                acc_cnt[i]  <= acc_cnt[i] + 1;
                seq[i]      <= seq[i] + 1;
                beat_idx[i] <= (beat_idx[i] >= src_len[i] - 1) ? 0 : beat_idx[i] + 1;
            end
        end
    end

    // output monitor
    logic [2:0] log_ch [512];
    logic       log_sop [512];
    logic       log_eop [512];
    int log_n = 0;
    int out_total = 0;
    int onehot_bad = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready && log_n < 512) begin
                log_ch[log_n]  <= out_chan;
                log_sop[log_n] <= out_sop;
                log_eop[log_n] <= out_eop;
                log_n          <= log_n + 1;
            end
            if (out_valid && out_ready) out_total <= out_total + 1;
            if ($countones(in_ready) > 1) onehot_bad <= onehot_bad + 1;
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wait_acc(input int i, input int target, input int limit, output bit ok);
        ok = 1'b0;
        for (int c = 0; c < limit && !ok; c++) begin
            @(negedge clk);
            if (acc_cnt[i] >= target) ok = 1'b1;
        end
    endtask

    task automatic wait_log(input int target, input int limit, output bit ok);
        ok = 1'b0;
        for (int c = 0; c < limit && !ok; c++) begin
            @(negedge clk);
            if (log_n >= target) ok = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) @(negedge clk);
    endtask

    // stimulus/expected table: {input index[1:0], chan bit, expected out_chan[2:0]}
    localparam int ROWS = 5;
    localparam logic [5:0] TBL [ROWS] = '{
        {2'd0, 1'b0, 3'b000},
        {2'd1, 1'b1, 3'b011},
        {2'd2, 1'b0, 3'b100},
        {2'd3, 1'b1, 3'b111},
        {2'd2, 1'b1, 3'b101}
    };

    initial begin
        bit ok;
        int base, a0, a1, a2, a3;
        logic [DW-1:0] held;

        // R9: reset with every source requesting
        src_on = '1;
        idle(3);
        chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        chk(in_ready == '0, "R9", "in_ready in reset", int'(in_ready), 0);
        src_on = '0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R5 / R10: table of single beats, tag checked right after acceptance
        for (int r = 0; r < ROWS; r++) begin
            int ii;
            ii = int'(TBL[r][5:4]);
            chan_val[ii] = TBL[r][3];
            a0 = acc_cnt[ii];
            src_on[ii] = 1'b1;
            wait_acc(ii, a0 + 1, 20, ok);
            src_on[ii] = 1'b0;
            chk(ok, "R5", "table beat accepted", int'(ok), 1);
            chk(out_valid && out_chan == TBL[r][2:0], "R5", "table out_chan",
                int'(out_chan), int'(TBL[r][2:0]));
            chk(out_data[31:24] == 8'(ii), "R10", "table out_data source byte",
                int'(out_data[31:24]), ii);
            idle(3);
        end

        // R2 / R3: continuous requests on all inputs, one-beat packets
        idle(3);
        base = log_n;
        src_on = '1;
        wait_log(base + 16, 200, ok);
        src_on = '0;
        chk(ok, "R3", "rotation beats collected", log_n - base, 16);
        for (int k = 0; k < 16; k++) begin
            int e;
            e = (3 + k / 2) % N;
            chk(int'(log_ch[base + k][2:1]) == e, (k < 2) ? "R2" : "R3",
                "rotation order", int'(log_ch[base + k][2:1]), e);
        end
        idle(6);

        // R4: five-beat packet on input 1 is not broken by a waiting input 2
        base = log_n;
        a1 = acc_cnt[1];
        src_len[1] = 5;
        src_on[1] = 1'b1;
        wait_acc(1, a1 + 1, 20, ok);
        src_on[2] = 1'b1;
        wait_log(base + 6, 60, ok);
        src_on = '0;
        chk(ok, "R4", "packet beats collected", log_n - base, 6);
        for (int k = 0; k < 5; k++) begin
            chk(log_ch[base + k][2:1] == 2'd1, "R4", "packet beat source",
                int'(log_ch[base + k][2:1]), 1);
        end
        chk(log_sop[base] == 1'b1, "R4", "packet sop", int'(log_sop[base]), 1);
        chk(log_eop[base + 4] == 1'b1, "R4", "packet eop", int'(log_eop[base + 4]), 1);
        chk(log_ch[base + 5][2:1] == 2'd2, "R4", "next grant after eop",
            int'(log_ch[base + 5][2:1]), 2);
        idle(4);
        src_len[1] = 1;
        idle(2);

        // R6: backpressure holds output and blocks all inputs
        out_ready = 1'b0;
        a3 = acc_cnt[3];
        src_on[3] = 1'b1;
        idle(4);
        chk(out_valid == 1'b1, "R6", "out_valid under stall", int'(out_valid), 1);
        chk(out_chan[2:1] == 2'd3, "R6", "stalled tag", int'(out_chan[2:1]), 3);
        held = out_data;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(out_data == held && out_valid, "R6", "held data", int'(out_data), int'(held));
            chk(in_ready == '0, "R6", "in_ready while stalled", int'(in_ready), 0);
        end
        chk(acc_cnt[3] == a3 + 1, "R6", "beats taken during stall", acc_cnt[3], a3 + 1);
        src_on[3] = 1'b0;
        out_ready = 1'b1;
        idle(4);

        // R7: one-cycle pulse on input 2 while input 0 is mid-packet
        base = log_n;
        a0 = acc_cnt[0];
        src_len[0] = 8;
        src_on[0] = 1'b1;
        wait_acc(0, a0 + 2, 20, ok);
        a2 = acc_cnt[2];
        src_on[2] = 1'b1;
        @(negedge clk);
        chk(in_ready[2] == 1'b0, "R7", "ready on pulsed input", int'(in_ready[2]), 0);
        src_on[2] = 1'b0;
        wait_acc(0, a0 + 8, 40, ok);
        src_on[0] = 1'b0;
        idle(5);
        chk(acc_cnt[2] == a2, "R7", "beats accepted from pulse", acc_cnt[2], a2);
        begin
            int seen;
            seen = 0;
            for (int k = base; k < log_n; k++) if (log_ch[k][2:1] == 2'd2) seen++;
            chk(seen == 0, "R7", "output beats tagged 2", seen, 0);
        end
        src_len[0] = 1;
        idle(2);

        // R8: granted input drops valid, another input gets served
        a1 = acc_cnt[1];
        src_on[1] = 1'b1;
        wait_acc(1, a1 + 1, 20, ok);
        src_on[1] = 1'b0;
        @(negedge clk);
        a3 = acc_cnt[3];
        src_on[3] = 1'b1;
        wait_acc(3, a3 + 1, 6, ok);
        src_on[3] = 1'b0;
        chk(ok, "R8", "other input served after drop", acc_cnt[3] - a3, 1);
        idle(6);

        // R1: conservation and single ready
        chk(out_total == acc_cnt[0] + acc_cnt[1] + acc_cnt[2] + acc_cnt[3], "R1",
            "output beats vs accepted beats", out_total,
            acc_cnt[0] + acc_cnt[1] + acc_cnt[2] + acc_cnt[3]);
        chk(onehot_bad == 0, "R1", "cycles with several ready bits", onehot_bad, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule